// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches a bank of general-purpose input pins and turns changes or levels on them into per-pin interrupt requests. Each pin is captured into a register, optionally passed through a debounce filter, and then compared with its value one cycle earlier. Software chooses, per pin, which of four trigger conditions are active: a rising edge, a falling edge, a high level or a low level. Any active condition that holds sets a sticky bit in an interrupt-state vector.

Software drives the block through one narrow write port: a strobe, a 3-bit selector and a data word. The selector picks one of the six stored control vectors, a write-one-to-clear action on the state vector, or a test action that forces state bits to one. The block reports the selected pin value (filtered or unfiltered, per pin), the state vector, and registered interrupt lines gated by an interrupt-enable vector.

Each pin's filter is a two-state machine. In STEADY the filter holds its accepted value; a differing input moves it to SETTLE. In SETTLE a counter runs while the input keeps differing; the input returning to the accepted value moves it back to STEADY, and the counter reaching the stable length commits the new value and also moves back to STEADY.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted and right after it, pin_value, irq_state and irq_line are all zero, and every control vector is zero.
- R2: A write with cfg_wr high stores cfg_wdata according to cfg_sel: 0 rising enables, 1 falling enables, 2 level-high enables, 3 level-low enables, 4 filter enables, 5 interrupt enables, 6 clears state bits where the data holds a one, 7 sets state bits where the data holds a one; each takes effect on the next clock edge and touches nothing else.
- R3: For a pin whose filter enable is 0, pin_value shows the pin as captured on the previous clock edge (one cycle of latency).
- R4: For a pin whose filter enable is 1, pin_value takes a new level only after the captured input has held that level for 16 consecutive cycles; a pulse shorter than that never appears and raises no event.
- R5: With its rising enable set, a pin going from 0 to 1 sets its state bit two edges after the pin changes (unfiltered); pins without the enable are not set.
- R6: With its falling enable set, a pin going from 1 to 0 sets its state bit two edges after the pin changes.
- R7: With its level-high (level-low) enable set, a pin that is 1 (0) sets its state bit on every edge while the condition holds.
- R8: A clear write removes exactly the state bits written as one, on the next edge; a bit written as zero is unchanged.
- R9: A test write sets every state bit written as one on the next edge.
- R10: When a trigger event and a clear hit the same state bit on the same edge, the bit ends up set.
- R11: irq_line is the state vector ANDed with the interrupt-enable vector, registered one edge later.
- R12: A pin that is already high when reset is released produces no rising event, even if its rising enable is written in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_in | input | 32 | Raw input pins |
| cfg_wr | input | 1 | Write strobe, one action per cycle it is high |
| cfg_sel | input | 3 | Action selector (see R2) |
| cfg_wdata | input | 32 | Write data, one bit per pin |
| pin_value | output | 32 | Captured pin value, filtered where enabled |
| irq_state | output | 32 | Sticky interrupt-state vector |
| irq_line | output | 32 | Registered, enable-gated interrupt lines |

## Verification
The two functions that can land on the same edge are a hardware trigger setting a state bit and a software clear removing it. The bench provokes the collision twice: once with a level-high trigger held on a pin while its bit is cleared, and once by timing a clear write to reach the same edge as a rising-edge event. In both cases the state bit must still read one after that edge, and a later clear with the trigger gone must remove it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Selector codes on the write port; the code order is fixed by the port contract.
    typedef enum logic [2:0] {
        SEL_RISE  = 3'd0,
        SEL_FALL  = 3'd1,
        SEL_HIGH  = 3'd2,
        SEL_LOW   = 3'd3,
        SEL_FILT  = 3'd4,
        SEL_IRQEN = 3'd5,
        SEL_CLEAR = 3'd6,
        SEL_TEST  = 3'd7
    } cfg_sel_e;

    // Number of selector codes that address a stored vector.
    localparam int NUM_STORED = 6;

    // Debounce filter states.
    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_SETTLE = 1'b1
    } flt_state_e;

endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_irq_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    flt_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            val_q, val_d;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            cnt_q   <= '0;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            val_q   <= val_d;
        end
    end

    // Next-state and output process.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        val_d   = val_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (raw_i != val_q) begin
                    state_d = FLT_SETTLE;
                    cnt_d   = CW'(1);
                end
            end
            FLT_SETTLE: begin
                if (raw_i == val_q) begin
                    state_d = FLT_STEADY;
                    cnt_d   = '0;
                end else if (cnt_q >= LAST) begin
                    state_d = FLT_STEADY;
                    cnt_d   = '0;
                    val_d   = raw_i;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = FLT_STEADY;
                cnt_d   = '0;
            end
        endcase
    end

    assign filt_o = val_q;

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_sel,
    input  logic [NUM_PINS-1:0] cfg_wdata,
    output logic [NUM_PINS-1:0] rise_en,
    output logic [NUM_PINS-1:0] fall_en,
    output logic [NUM_PINS-1:0] high_en,
    output logic [NUM_PINS-1:0] low_en,
    output logic [NUM_PINS-1:0] filt_en,
    output logic [NUM_PINS-1:0] irq_en,
    output logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] test_mask
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    // One stored vector per selector code below NUM_STORED.
    for (genvar g = 0; g < NUM_STORED; g++) begin : g_vec
        logic [NUM_PINS-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (cfg_wr && (cfg_sel == 3'(g))) begin
                q <= cfg_wdata;
            end
        end
    end

    assign rise_en = g_vec[0].q;
    assign fall_en = g_vec[1].q;
    assign high_en = g_vec[2].q;
    assign low_en  = g_vec[3].q;
    assign filt_en = g_vec[4].q;
    assign irq_en  = g_vec[5].q;

    // Action codes produce one-cycle masks rather than stored state.
    assign clr_mask  = (cfg_wr && sel == SEL_CLEAR) ? cfg_wdata : '0;
    assign test_mask = (cfg_wr && sel == SEL_TEST)  ? cfg_wdata : '0;

endmodule

// File: rtl/gpio_trigger_detect.sv
module gpio_trigger_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] level_i,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic [NUM_PINS-1:0] high_en,
    input  logic [NUM_PINS-1:0] low_en,
    output logic [NUM_PINS-1:0] event_o
);

    logic [NUM_PINS-1:0] prev_q;
    logic [1:0]          arm_q;
    logic [NUM_PINS-1:0] edge_ok;
    logic [NUM_PINS-1:0] rose, fell;

    // arm_q[1] is set once prev_q holds a value captured after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            arm_q  <= '0;
        end else begin
            prev_q <= level_i;
            arm_q  <= {arm_q[0], 1'b1};
        end
    end

    assign edge_ok = {NUM_PINS{arm_q[1]}};
    assign rose    = level_i & ~prev_q;
    assign fell    = ~level_i & prev_q;

    assign event_o = (((rise_en & rose) | (fall_en & fell)) & edge_ok)
                   | (high_en & level_i)
                   | (low_en & ~level_i);

endmodule

// File: rtl/gpio_irq_state.sv
module gpio_irq_state #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] event_i,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic [NUM_PINS-1:0] test_mask,
    input  logic [NUM_PINS-1:0] irq_en,
    output logic [NUM_PINS-1:0] state_o,
    output logic [NUM_PINS-1:0] line_o
);

    logic [NUM_PINS-1:0] state_q, line_q;

    // Set terms are ORed after the clear, so a set always wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            line_q  <= '0;
        end else begin
            state_q <= (state_q & ~clr_mask) | event_i | test_mask;
            line_q  <= state_q & irq_en;
        end
    end

    assign state_o = state_q;
    assign line_o  = line_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS      = 32,
    parameter int STABLE_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_in,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_sel,
    input  logic [NUM_PINS-1:0] cfg_wdata,
    output logic [NUM_PINS-1:0] pin_value,
    output logic [NUM_PINS-1:0] irq_state,
    output logic [NUM_PINS-1:0] irq_line
);

    logic [NUM_PINS-1:0] raw_q;
    logic [NUM_PINS-1:0] filt_val;
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] rise_en, fall_en, high_en, low_en, filt_en, irq_en;
    logic [NUM_PINS-1:0] clr_mask, test_mask;
    logic [NUM_PINS-1:0] event_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= pins_in;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_filt
        gpio_pin_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_q[p]),
            .filt_o (filt_val[p])
        );
    end

    assign level     = (filt_en & filt_val) | (~filt_en & raw_q);
    assign pin_value = level;

    gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .high_en   (high_en),
        .low_en    (low_en),
        .filt_en   (filt_en),
        .irq_en    (irq_en),
        .clr_mask  (clr_mask),
        .test_mask (test_mask)
    );

    gpio_trigger_detect #(.NUM_PINS(NUM_PINS)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .high_en (high_en),
        .low_en  (low_en),
        .event_o (event_vec)
    );

    gpio_irq_state #(.NUM_PINS(NUM_PINS)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (event_vec),
        .clr_mask  (clr_mask),
        .test_mask (test_mask),
        .irq_en    (irq_en),
        .state_o   (irq_state),
        .line_o    (irq_line)
    );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pins_in,
    input logic                cfg_wr,
    input logic [2:0]          cfg_sel,
    input logic [NUM_PINS-1:0] cfg_wdata,
    input logic [NUM_PINS-1:0] pin_value,
    input logic [NUM_PINS-1:0] irq_state,
    input logic [NUM_PINS-1:0] irq_line,
    input logic [NUM_PINS-1:0] filt_en,
    input logic [NUM_PINS-1:0] irq_en,
    input logic [NUM_PINS-1:0] event_vec
);

    logic                is_clear, is_test;
    logic [NUM_PINS-1:0] clr_seen;
    assign is_clear = cfg_wr && (cfg_sel == 3'd6);
    assign is_test  = cfg_wr && (cfg_sel == 3'd7);
    assign clr_seen = is_clear ? cfg_wdata : '0;

    // R3: unfiltered pins show the input from one edge earlier
    assert_unfiltered_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_value ^ $past(pins_in)) & ~filt_en) == '0));

    // R8: only bits written as one by a clear may drop
    assert_clear_only_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irq_state) & ~$past(clr_seen)) & ~irq_state) == '0));

    // R9: a test write sets its bits
    assert_test_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> ((irq_state & $past(cfg_wdata)) == $past(cfg_wdata)));

    // R10: a trigger event sets its bit even against a clear
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_vec) |=> ((irq_state & $past(event_vec)) == $past(event_vec)));

    // R11: lines are the gated state of one edge earlier
    assert_line_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_line == ($past(irq_state) & $past(irq_en))));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_in   (pins_in),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .pin_value (pin_value),
    .irq_state (irq_state),
    .irq_line  (irq_line),
    .filt_en   (filt_en),
    .irq_en    (irq_en),
    .event_vec (event_vec)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;

    localparam int CLK_PERIOD = 10;
    localparam int SIG_PIN = 0, SIG_STATE = 1, SIG_LINE = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pins_in;
    logic        cfg_wr;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] pin_value, irq_state, irq_line;

    gpio_irq_detect dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_in   (pins_in),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pin_value (pin_value),
        .irq_state (irq_state),
        .irq_line  (irq_line)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        int          sig;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          compared = 0;
    int          mismatched = 0;
    bit          done = 1'b0;
    logic [31:0] act;

    // Driver side: push an expected value for an absolute cycle.
    task automatic expect_at(input int at, input int sig, input logic [31:0] exp, input string tag);
        item_t it;
        it.at = at; it.sig = sig; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor side: compare items due in this cycle, away from the edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                case (sb[i].sig)
                    SIG_PIN:   act = pin_value;
                    SIG_STATE: act = irq_state;
                    default:   act = irq_line;
                endcase
                compared++;
                if (act !== sb[i].exp) begin
                    mismatched++;
                    $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h",
                             sb[i].tag, sb[i].sig, cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called just after a negedge; the write lands on the next edge.
    task automatic cfg(input logic [2:0] s, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int c;
        rst_n = 1'b0; pins_in = 32'h8000_0000;
        cfg_wr = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0;
        step(2);
        // R1: outputs zero in reset
        c = cyc;
        expect_at(c + 1, SIG_PIN,   32'h0, "R1");
        expect_at(c + 1, SIG_STATE, 32'h0, "R1");
        expect_at(c + 1, SIG_LINE,  32'h0, "R1");
        step(1);
        // R12: pin 31 high through reset, rising enable written at once
        rst_n = 1'b1;
        c = cyc;
        expect_at(c + 1, SIG_PIN,   32'h8000_0000, "R3");
        expect_at(c + 2, SIG_STATE, 32'h0, "R12");
        expect_at(c + 4, SIG_STATE, 32'h0, "R12");
        cfg(3'd0, 32'h8000_0000);
        step(4);
        pins_in = 32'h0;
        step(3);
        cfg(3'd5, 32'hFFFF_FFFF);
        cfg(3'd0, 32'h0000_0001);

        // R5: rising on pin 0; pin 1 rises without enable
        c = cyc;
        pins_in = 32'h3;
        expect_at(c + 1, SIG_PIN,   32'h3, "R3");
        expect_at(c + 1, SIG_STATE, 32'h0, "R5");
        expect_at(c + 2, SIG_STATE, 32'h1, "R5");
        expect_at(c + 3, SIG_LINE,  32'h1, "R11");
        step(4);

        // R8: zero write keeps, one write clears
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h1, "R8");
        cfg(3'd6, 32'h0);
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h0, "R8");
        expect_at(c + 2, SIG_LINE,  32'h0, "R11");
        cfg(3'd6, 32'h1);
        step(2);

        // R6: falling on pin 1
        cfg(3'd1, 32'h2);
        c = cyc;
        pins_in = 32'h1;
        expect_at(c + 2, SIG_STATE, 32'h2, "R6");
        step(3);
        cfg(3'd6, 32'h2);

        // R7: level high on pin 0, then R10 clear against held level
        c = cyc;
        expect_at(c + 2, SIG_STATE, 32'h1, "R7");
        cfg(3'd2, 32'h1);
        step(2);
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h1, "R10");
        cfg(3'd6, 32'h1);
        cfg(3'd2, 32'h0);
        cfg(3'd6, 32'h1);
        // R7: level low on pin 2
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h0, "R7");
        expect_at(c + 2, SIG_STATE, 32'h4, "R7");
        cfg(3'd3, 32'h4);
        step(2);
        cfg(3'd3, 32'h0);
        cfg(3'd6, 32'h4);

        // R10: rising edge on pin 3 meets a clear on the same edge
        cfg(3'd0, 32'h8);
        c = cyc;
        pins_in = 32'h9;
        expect_at(c + 2, SIG_STATE, 32'h8, "R10");
        expect_at(c + 3, SIG_STATE, 32'h8, "R10");
        step(1);
        cfg(3'd6, 32'h8);
        step(2);
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h0, "R8");
        cfg(3'd6, 32'h8);

        // R9: test write sets bits, lines follow
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h00F0_0000, "R9");
        expect_at(c + 2, SIG_LINE,  32'h00F0_0000, "R9");
        cfg(3'd7, 32'h00F0_0000);
        step(1);
        cfg(3'd6, 32'hFFFF_FFFF);

        // R2 / R11: narrower interrupt enables gate the lines
        cfg(3'd5, 32'h0000_FF00);
        c = cyc;
        expect_at(c + 1, SIG_STATE, 32'h0101_0100, "R2");
        expect_at(c + 2, SIG_LINE,  32'h0000_0100, "R11");
        cfg(3'd7, 32'h0101_0100);
        step(1);
        cfg(3'd6, 32'hFFFF_FFFF);

        // R4: filtered pin 4 rejects a 5-cycle pulse
        cfg(3'd4, 32'h10);
        cfg(3'd0, 32'h10);
        c = cyc;
        pins_in = 32'h19;
        step(5);
        pins_in = 32'h9;
        expect_at(c + 6,  SIG_PIN,   32'h9, "R4");
        expect_at(c + 20, SIG_PIN,   32'h9, "R4");
        expect_at(c + 22, SIG_STATE, 32'h0, "R4");
        step(25);

        // R4: a held level is accepted after 16 stable cycles
        c = cyc;
        pins_in = 32'h19;
        expect_at(c + 16, SIG_PIN,   32'h9,  "R4");
        expect_at(c + 17, SIG_PIN,   32'h19, "R4");
        expect_at(c + 17, SIG_STATE, 32'h0,  "R4");
        expect_at(c + 18, SIG_STATE, 32'h10, "R5");
        step(22);

        step(3);
        if (sb.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule